// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Manager

This block keeps an already initialized SDRAM refreshed and handles its clock-enable low-power states. A free-running interval timer produces refresh ticks. Ticks that cannot be served at once, for example because a long burst holds the bus, are kept in a saturating backlog. The manager asks the main command arbiter for the bus. Once the arbiter grants it, all banks are idle and no burst is running, the manager takes over the command pins. It then issues an auto-refresh, lowers CKE into power-down, or enters self-refresh. While it owns the pins it raises a busy flag, which the arbiter must honour.

On exit from a low-power state the manager raises CKE and holds the bus for the recovery time before handing it back. After an auto-refresh or a self-refresh exit, that recovery is tRFC rounded up to whole clocks. A refresh tick that arrives during power-down wakes the device first and is then served like any other refresh. The interval and tRFC are given in nanoseconds and converted with a clock-frequency parameter.

Top module: `sdr_pwr_refresh_mgr`

## Requirements
- R1: The refresh interval in clocks is floor(REFI_NS*CLK_MHZ/1000) (3120 at defaults). A tick occurs every that many cycles, the first one in cycle REFI_CLK-1 after reset. In the run state `arb_req` is high whenever the backlog is non-zero or `pd_req` or `sr_req` is high; in every other state it is low.
- R2: An action starts only in a cycle where `arb_req`, `arb_grant` and `banks_idle` are high and `burst_active` is low. The command appears one clock later on `cmd_code` = {cs_n, ras_n, cas_n, we_n}. Auto-refresh is 4'b0001 and NOP is 4'b0111.
- R3: After an auto-refresh presented in cycle k, `bus_busy` stays high until cycle k+TRFC_CLK. TRFC_CLK = max(2, ceil(TRFC_NS*CLK_MHZ/1000)), which is 12 at defaults.
- R4: CKE is lowered only by an action started under the R2 conditions. It is never lowered while `burst_active` is high or a bank is open.
- R5: While CKE is low, `cmd_ovr` and `bus_busy` are high. `cmd_code` is NOP, except in the single self-refresh entry cycle.
- R6: Power-down exit raises CKE for exactly one busy NOP cycle before the bus is released.
- R7: Self-refresh entry drives auto-refresh on `cmd_code` in the same cycle CKE goes low. Entry clears the backlog, and ticks are discarded while the device is in self-refresh.
- R8: Self-refresh exit keeps CKE high and `bus_busy` high for exactly TRFC_CLK cycles.
- R9: The backlog counts up to MAX_PEND (8) missed ticks. Once the bus is free, the stored refreshes are issued back to back, one every TRFC_CLK+1 cycles while the grant is held.
- R10: A tick arriving during power-down makes the block leave power-down. It then requests the bus and issues the refresh. If `pd_req` is still high afterwards, it re-enters power-down.
- R11: During and right after reset, CKE is high, `cmd_ovr`, `bus_busy` and `arb_req` are low, and `cmd_code` is NOP.
- R12: When several actions are possible, refresh wins over self-refresh, and self-refresh wins over power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in flight |
| pd_req | input | 1 | Host level request for power-down |
| sr_req | input | 1 | Host level request for self-refresh |
| arb_grant | input | 1 | Bus grant from the main command arbiter |
| arb_req | output | 1 | Bus request to the arbiter |
| cke | output | 1 | Clock enable to the SDRAM |
| cmd_ovr | output | 1 | Manager drives the command pins |
| cmd_code | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| bus_busy | output | 1 | Arbiter must not issue commands |

## Verification
The hardest state to reach is a backlog of several pending refreshes. Ticks come only every few thousand cycles, and a free bus drains them at once. Directed phases therefore hold `burst_active` high across three intervals, and then across ten intervals to hit saturation, before releasing the bus and counting the back-to-back refreshes. A held power-down request is kept across a tick to reach the wake-and-refresh path. A long random phase then mixes grants, bank status and host requests. A bench model tracks the expected outputs in every cycle throughout.

// File: rtl/sdr_pm_pkg.sv
`timescale 1ns/1ps
package sdr_pm_pkg;

    // command on {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sdr_cmd_t;
    localparam sdr_cmd_t CMD_NOP  = 4'b0111;
    localparam sdr_cmd_t CMD_AREF = 4'b0001;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_AREF,
        ST_RFC,
        ST_PD,
        ST_PD_EXIT,
        ST_SR_ENTER,
        ST_SR,
        ST_SR_EXIT
    } pm_state_e;

    typedef struct packed {
        logic     cke;
        logic     ovr;
        logic     busy;
        sdr_cmd_t cmd;
    } pm_drive_t;

    function automatic int unsigned ns_to_clk_up(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int unsigned ns_to_clk_down(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

    function automatic pm_drive_t drive_of(input pm_state_e st);
        pm_drive_t d;
        d.cke  = 1'b1;
        d.ovr  = 1'b1;
        d.busy = 1'b1;
        d.cmd  = CMD_NOP;
        case (st)
            ST_RUN: begin
                d.ovr  = 1'b0;
                d.busy = 1'b0;
            end
            ST_AREF:     d.cmd = CMD_AREF;
            ST_SR_ENTER: begin
                d.cke = 1'b0;
                d.cmd = CMD_AREF;
            end
            ST_PD, ST_SR: d.cke = 1'b0;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sdr_refi_timer.sv
`timescale 1ns/1ps
module sdr_refi_timer #(
    parameter int unsigned PERIOD = 3120
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [TW-1:0] cnt;

    assign tick = (cnt == TW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdr_ref_backlog.sv
`timescale 1ns/1ps
module sdr_ref_backlog #(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold_off,
    input  logic take,
    input  logic clr,
    output logic pend_nz
);
    generate
        if (MAX_PEND <= 1) begin : g_flag
            logic flag;
            always_ff @(posedge clk) begin
                if (rst || clr) flag <= 1'b0;
                else            flag <= (flag && !take) || (tick && !hold_off && !flag);
            end
            assign pend_nz = flag;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(MAX_PEND + 1);
            logic [CW-1:0] cnt;
            logic          inc;
            assign inc = tick && !hold_off && (cnt != CW'(MAX_PEND));
            always_ff @(posedge clk) begin
                if (rst || clr) cnt <= '0;
                else            cnt <= cnt + CW'(inc) - CW'(take);
            end
            assign pend_nz = (cnt != '0);
        end
    endgenerate
endmodule

// File: rtl/sdr_pm_fsm.sv
`timescale 1ns/1ps
module sdr_pm_fsm
    import sdr_pm_pkg::*;
#(
    parameter int unsigned TRFC_CLK = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pend_nz,
    input  logic      banks_idle,
    input  logic      burst_active,
    input  logic      pd_req,
    input  logic      sr_req,
    input  logic      grant,
    output pm_state_e state,
    output logic      arb_req,
    output pm_drive_t drv
);
    localparam int unsigned RW = (TRFC_CLK > 2) ? $clog2(TRFC_CLK) : 1;

    pm_state_e     nxt;
    logic [RW-1:0] rcnt, rcnt_nxt;
    logic          go;

    assign arb_req = (state == ST_RUN) && (pend_nz || pd_req || sr_req);
    assign go      = arb_req && grant && banks_idle && !burst_active;
    assign drv     = drive_of(state);

    always_comb begin
        nxt      = state;
        rcnt_nxt = rcnt;
        case (state)
            ST_RUN: begin
                if (go) begin
                    if (pend_nz)     nxt = ST_AREF;
                    else if (sr_req) nxt = ST_SR_ENTER;
                    else             nxt = ST_PD;
                end
            end
            ST_AREF: begin
                nxt      = ST_RFC;
                rcnt_nxt = RW'(TRFC_CLK - 2);
            end
            ST_RFC: begin
                if (rcnt == '0) nxt = ST_RUN;
                else            rcnt_nxt = rcnt - 1'b1;
            end
            ST_PD: begin
                if (!pd_req || pend_nz || sr_req) nxt = ST_PD_EXIT;
            end
            ST_PD_EXIT:  nxt = ST_RUN;
            ST_SR_ENTER: nxt = ST_SR;
            ST_SR: begin
                if (!sr_req) begin
                    nxt      = ST_SR_EXIT;
                    rcnt_nxt = RW'(TRFC_CLK - 1);
                end
            end
            ST_SR_EXIT: begin
                if (rcnt == '0) nxt = ST_RUN;
                else            rcnt_nxt = rcnt - 1'b1;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            rcnt  <= '0;
        end else begin
            state <= nxt;
            rcnt  <= rcnt_nxt;
        end
    end
endmodule

// File: rtl/sdr_pwr_refresh_mgr.sv
`timescale 1ns/1ps
module sdr_pwr_refresh_mgr
    import sdr_pm_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 200,
    parameter int unsigned REFI_NS  = 15600,
    parameter int unsigned TRFC_NS  = 60,
    parameter int unsigned MAX_PEND = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       banks_idle,
    input  logic       burst_active,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       arb_grant,
    output logic       arb_req,
    output logic       cke,
    output logic       cmd_ovr,
    output logic [3:0] cmd_code,
    output logic       bus_busy
);
    localparam int unsigned REFI_RAW = ns_to_clk_down(REFI_NS, CLK_MHZ);
    localparam int unsigned REFI_CLK = (REFI_RAW < 2) ? 2 : REFI_RAW;
    localparam int unsigned TRFC_RAW = ns_to_clk_up(TRFC_NS, CLK_MHZ);
    localparam int unsigned TRFC_CLK = (TRFC_RAW < 2) ? 2 : TRFC_RAW;

    logic      tick, pend_nz;
    pm_state_e state;
    pm_drive_t drv;

    sdr_refi_timer #(.PERIOD(REFI_CLK)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sdr_ref_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .hold_off (state == ST_SR_ENTER || state == ST_SR),
        .take     (state == ST_AREF),
        .clr      (state == ST_SR_ENTER),
        .pend_nz  (pend_nz)
    );

    sdr_pm_fsm #(.TRFC_CLK(TRFC_CLK)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pend_nz      (pend_nz),
        .banks_idle   (banks_idle),
        .burst_active (burst_active),
        .pd_req       (pd_req),
        .sr_req       (sr_req),
        .grant        (arb_grant),
        .state        (state),
        .arb_req      (arb_req),
        .drv          (drv)
    );

    assign cke      = drv.cke;
    assign cmd_ovr  = drv.ovr;
    assign bus_busy = drv.busy;
    assign cmd_code = drv.cmd;
endmodule

// File: rtl/sdr_pwr_refresh_mgr_chk.sv
`timescale 1ns/1ps
module sdr_pwr_refresh_mgr_chk #(
    parameter int unsigned TRFC_CLK = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       banks_idle,
    input logic       burst_active,
    input logic       arb_req,
    input logic       cke,
    input logic       cmd_ovr,
    input logic [3:0] cmd_code,
    input logic       bus_busy
);
    localparam int unsigned WW = $clog2(TRFC_CLK + 1);
    logic [WW-1:0] rfc_win;

    always_ff @(posedge clk) begin
        if (rst)                              rfc_win <= '0;
        else if (cke && cmd_code == 4'b0001)  rfc_win <= WW'(TRFC_CLK - 1);
        else if (rfc_win != '0)               rfc_win <= rfc_win - 1'b1;
    end

    // R1
    req_only_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        arb_req |-> (cke && !bus_busy));

    // R3
    rfc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rfc_win != '0) |-> bus_busy);

    // R4
    cke_drop_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> $past(banks_idle && !burst_active));

    // R5
    cke_low_owned_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd_ovr && bus_busy && (cmd_code == 4'b0111 || cmd_code == 4'b0001)));

    // R6
    wake_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (bus_busy && cmd_code == 4'b0111));

    // R7
    sr_entry_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && cmd_code == 4'b0001) |=> (!cke && cmd_code == 4'b0111));
endmodule

bind sdr_pwr_refresh_mgr sdr_pwr_refresh_mgr_chk #(.TRFC_CLK(TRFC_CLK)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .arb_req      (arb_req),
    .cke          (cke),
    .cmd_ovr      (cmd_ovr),
    .cmd_code     (cmd_code),
    .bus_busy     (bus_busy)
);

// File: tb/sdr_pwr_refresh_mgr_tb.sv
`timescale 1ns/1ps
module sdr_pwr_refresh_mgr_tb;
    localparam int REFI = 15600 * 200 / 1000;
    localparam int TRFC = (60 * 200 + 999) / 1000;
    localparam int MAXP = 8;
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] AREF = 4'b0001;
    localparam int M_RUN = 0, M_AREF = 1, M_RFC = 2, M_PD = 3, M_PDX = 4,
                   M_SRE = 5, M_SR = 6, M_SRX = 7;

    logic clk = 0, rst = 1;
    logic banks_idle = 1, burst_active = 0, pd_req = 0, sr_req = 0, arb_grant = 0;
    logic arb_req, cke, cmd_ovr, bus_busy;
    logic [3:0] cmd_code;

    int n_chk = 0, n_fail = 0, n_aref = 0;
    int m_tcnt = 0, m_pend = 0, m_mode = M_RUN, m_cnt = 0;

    always #2.5 clk = ~clk;

    sdr_pwr_refresh_mgr u_dut (
        .clk(clk), .rst(rst), .banks_idle(banks_idle), .burst_active(burst_active),
        .pd_req(pd_req), .sr_req(sr_req), .arb_grant(arb_grant), .arb_req(arb_req),
        .cke(cke), .cmd_ovr(cmd_ovr), .cmd_code(cmd_code), .bus_busy(bus_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_cke(input int md);
        return (md == M_PD || md == M_SR || md == M_SRE) ? 0 : 1;
    endfunction
    function automatic int exp_cmd(input int md);
        return (md == M_AREF || md == M_SRE) ? int'(AREF) : int'(NOP);
    endfunction
    function automatic int exp_arb(input int md, input int pend);
        return (md == M_RUN && (pend > 0 || pd_req || sr_req)) ? 1 : 0;
    endfunction

    // compare outputs to the model, then advance the model and the clock
    task automatic step();
        int tick, n_tcnt, n_pend, n_mode, n_cnt, go;
        #1;
        chk("R4", "cke", int'(cke), exp_cke(m_mode));
        chk("R2", "cmd_code", int'(cmd_code), exp_cmd(m_mode));
        chk("R3", "bus_busy", int'(bus_busy), (m_mode == M_RUN) ? 0 : 1);
        chk("R5", "cmd_ovr", int'(cmd_ovr), (m_mode == M_RUN) ? 0 : 1);
        chk("R1", "arb_req", int'(arb_req), exp_arb(m_mode, m_pend));
        if (cke && cmd_code == AREF) n_aref++;
        tick   = (m_tcnt == REFI - 1);
        n_tcnt = tick ? 0 : m_tcnt + 1;
        if (m_mode == M_SRE) n_pend = 0;
        else begin
            n_pend = m_pend;
            if (tick && m_mode != M_SR && m_pend < MAXP) n_pend++;
            if (m_mode == M_AREF) n_pend--;
        end
        n_mode = m_mode; n_cnt = m_cnt;
        go = exp_arb(m_mode, m_pend) && arb_grant && banks_idle && !burst_active;
        case (m_mode)
            M_RUN: if (go) n_mode = (m_pend > 0) ? M_AREF : (sr_req ? M_SRE : M_PD);
            M_AREF: begin n_mode = M_RFC; n_cnt = TRFC - 2; end
            M_RFC: if (m_cnt == 0) n_mode = M_RUN; else n_cnt--;
            M_PD:  if (!pd_req || m_pend > 0 || sr_req) n_mode = M_PDX;
            M_PDX: n_mode = M_RUN;
            M_SRE: n_mode = M_SR;
            M_SR:  if (!sr_req) begin n_mode = M_SRX; n_cnt = TRFC - 1; end
            M_SRX: if (m_cnt == 0) n_mode = M_RUN; else n_cnt--;
            default: n_mode = M_RUN;
        endcase
        @(posedge clk);
        m_tcnt = n_tcnt; m_pend = n_pend; m_mode = n_mode; m_cnt = n_cnt;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int a0, busy_len, saw_pd, saw_aref, repd;
        void'($urandom(32'h5EED_0C1E));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "cke in reset", int'(cke), 1);
        chk("R11", "busy in reset", int'(bus_busy), 0);
        chk("R11", "ovr in reset", int'(cmd_ovr), 0);
        chk("R11", "arb_req in reset", int'(arb_req), 0);
        chk("R11", "cmd in reset", int'(cmd_code), int'(NOP));
        rst = 0;
        arb_grant = 1;

        // R1: first refresh appears at cycle REFI+1 after reset
        a0 = -1;
        for (int i = 0; i < REFI + 5; i++) begin
            if (a0 < 0 && cke && cmd_code == AREF) a0 = i;
            step();
        end
        chk("R1", "first refresh cycle", a0, REFI + 1);

        // R9: three intervals of backlog behind a long burst
        burst_active = 1;
        repeat (3 * REFI) step();
        burst_active = 0;
        a0 = n_aref;
        repeat (3 * (TRFC + 1) + 20) step();
        chk("R9", "backlog of three served", ((n_aref - a0) >= 3 && (n_aref - a0) <= 4) ? 1 : 0, 1);

        // R9: saturation at MAX_PEND
        burst_active = 1;
        repeat (10 * REFI) step();
        burst_active = 0;
        a0 = n_aref;
        repeat (MAXP * (TRFC + 1) + 30) step();
        chk("R9", "saturated backlog", ((n_aref - a0) >= MAXP && (n_aref - a0) <= MAXP + 1) ? 1 : 0, 1);

        // R6: power-down exit is one busy NOP cycle
        pd_req = 1;
        for (int i = 0; i < 50 && cke; i++) step();
        chk("R4", "power-down entered", int'(cke), 0);
        repeat (20) step();
        pd_req = 0;
        for (int i = 0; i < 10 && !cke; i++) step();
        #1;
        chk("R6", "wake cycle busy", int'(bus_busy), 1);
        chk("R6", "wake cycle nop", int'(cmd_code), int'(NOP));
        step();
        #1;
        chk("R6", "bus released after wake", int'(bus_busy), (m_mode == M_RUN) ? 0 : 1);
        step();

        // R10: tick during power-down wakes, refreshes, re-enters
        pd_req = 1;
        saw_pd = 0; saw_aref = 0; repd = 0;
        for (int i = 0; i < 2 * REFI && !repd; i++) begin
            if (!cke && cmd_code == NOP && !saw_aref) saw_pd = 1;
            if (saw_pd && cke && cmd_code == AREF) saw_aref = 1;
            if (saw_aref && !cke) repd = 1;
            step();
        end
        chk("R10", "power-down then refresh then power-down", saw_pd + saw_aref + repd, 3);
        pd_req = 0;
        repeat (5) step();

        // R12, R7: both host requests, no backlog -> self-refresh entry
        pd_req = 1; sr_req = 1;
        for (int i = 0; i < 3 * TRFC + 10 && cke; i++) step();
        #1;
        chk("R12", "self-refresh chosen over power-down", int'(cmd_code), int'(AREF));
        chk("R7", "self-refresh entry cke", int'(cke), 0);
        pd_req = 0;
        repeat (60) step();
        // R8: exit recovery length
        sr_req = 0;
        for (int i = 0; i < 10 && !cke; i++) step();
        busy_len = 0;
        for (int i = 0; i < 3 * TRFC && bus_busy; i++) begin busy_len++; step(); end
        chk("R8", "self-refresh exit busy cycles", busy_len, TRFC);

        // random phase
        for (int i = 0; i < 40000; i++) begin
            banks_idle = ($urandom % 8) != 0;
            arb_grant  = ($urandom % 4) != 0;
            if ($urandom % 300 == 0) burst_active = ~burst_active;
            if ($urandom % 200 == 0) pd_req = ~pd_req;
            if ($urandom % 500 == 0) sr_req = ~sr_req;
            step();
        end

        // R11: reset in mid operation returns to idle outputs
        rst = 1;
        @(posedge clk); @(negedge clk);
        #1;
        chk("R11", "cke after reset", int'(cke), 1);
        chk("R11", "busy after reset", int'(bus_busy), 0);
        finish_run();
    end
endmodule